// File: doc/BRIEF.md
# Configurable Local Bus Master

This block turns single read and write requests from an on-chip host port into cycles on an external, ISA-style parallel bus. It has two chip selects. The host address carries one extra top bit that picks which window, and so which chip select, a request uses. The lower bits form the local address. One controller handles both bus styles. In the multiplexed style, the address and the data share one bus, and an address-latch strobe separates them. In the separate style, dedicated address lines carry the address, and the shared bus carries only data.

The data path can be 8 or 16 bits wide. On a 16-bit bus, the two bytes can optionally be exchanged to bridge between little-endian and big-endian slaves. Every phase of a cycle has a programmable length: the address phase, the strobe, and the idle turnaround that follows. A strobe ends in one of two ways. It ends after a fixed count, or it ends when the slave drives its ready input to the programmed active level. In the ready-terminated case, a bounded wait closes a cycle whose slave never answers, and the block reports an error. Both the address-latch strobe and the ready input have a selectable polarity.

The host presents a request by holding `req_valid` with the request fields stable until it sees the one-cycle `req_ack`. The read data and the error flag are valid in that same cycle. All configuration inputs are static and may change only while the bus is idle.

Top module: `lbus_master`

## Requirements
- R1: After a synchronous active-high reset, and whenever no cycle is in progress, both chip selects, the read strobe and the write strobe are high (inactive), the address latch is at its inactive level, the data bus is not driven (`lb_ad_oe`=0) and `req_ack` is 0.
- R2: Host address bit 16 selects the window: 0 drives `lb_cs0_n` low and 1 drives `lb_cs1_n` low. The selected chip select is low only during the address phase and the strobe phase, and the other chip select stays high.
- R3: In multiplexed style (`cfg_mux`=1), the address phase lasts `cfg_ale_cyc`+1 cycles. During it, the address latch is at its active level and `lb_ad_o` carries host address bits 15:0 with `lb_ad_oe`=1.
- R4: In separate style (`cfg_mux`=0), the address latch never leaves its inactive level. `lb_a` carries host address bits 10:1 for a 16-bit bus and bits 9:0 for an 8-bit bus, and the data bus is driven only with write data.
- R5: In counted mode (`cfg_use_rdy`=0), the strobe is low for `cfg_strb_cyc`+1 cycles. The strobe is `lb_rd_n` for a read and `lb_wr_n` for a write, and the two are never low together.
- R6: In ready mode (`cfg_use_rdy`=1), the strobe is released after the first clock edge at which `lb_rdy` equals `cfg_rdy_hi` (1 = active high, 0 = active low). The strobe therefore lasts as many cycles as the slave takes to become ready.
- R7: In ready mode, if ready is not seen within TMO_CYC strobe cycles, the strobe ends after exactly TMO_CYC cycles and `rsp_err`=1 with the acknowledge. In every other case `rsp_err`=0.
- R8: Write data on the bus is {8'h00, wdata[7:0]} on an 8-bit bus. On a 16-bit bus it is wdata, or {wdata[7:0], wdata[15:8]} when `cfg_swap`=1. It is driven for the whole strobe.
- R9: Read data is sampled from `lb_ad_i` at the edge that releases the strobe. It is formatted the same way as R8 (zero-extended low byte on an 8-bit bus, bytes exchanged on a 16-bit bus when `cfg_swap`=1). The bus is never driven while the read strobe is low.
- R10: `req_ack` is a single-cycle pulse in the cycle right after the strobe is released. `rsp_rdata` and `rsp_err` are valid in that cycle, and both strobes and both chip selects are already high.
- R11: After a strobe is released, the chip selects stay high for max(`cfg_turn_cyc`,1)+1 cycles before the next address phase starts, even when the next request is already waiting.
- R12: With `cfg_ale_hi`=0, the address latch is low when active and high when inactive. With `cfg_ale_hi`=1, it is high when active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Bit 16 picks the window, bits 15:0 are the local address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Formatted read data, valid with the acknowledge |
| rsp_err | output | 1 | Ready timeout, valid with the acknowledge |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = separate address lines |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_swap | input | 1 | Exchange bytes on a 16-bit bus |
| cfg_use_rdy | input | 1 | 1 = strobe ends on ready, 0 = strobe ends on count |
| cfg_ale_hi | input | 1 | Address latch active level |
| cfg_rdy_hi | input | 1 | Ready input active level |
| cfg_ale_cyc | input | 4 | Address phase length minus one |
| cfg_strb_cyc | input | 4 | Counted strobe length minus one |
| cfg_turn_cyc | input | 4 | Turnaround idle cycles |
| lb_ad_o | output | 16 | Shared address/data bus, outgoing value |
| lb_ad_oe | output | 1 | Drive enable for the shared bus |
| lb_ad_i | input | 16 | Shared bus, incoming value |
| lb_a | output | 10 | Separate-style address lines |
| lb_ale | output | 1 | Address latch strobe |
| lb_rd_n | output | 1 | Read strobe, active low |
| lb_wr_n | output | 1 | Write strobe, active low |
| lb_cs0_n | output | 1 | Chip select for window 0 |
| lb_cs1_n | output | 1 | Chip select for window 1 |
| lb_rdy | input | 1 | Slave ready |

## Verification
Transactions run in both bus styles, at both data widths, with and without the byte exchange, to tell the address phase on the shared bus apart from the address on the dedicated lines, and the zero-extended byte apart from the swapped word.

Counted strobes of different lengths run against ready-terminated strobes. In ready mode the bench varies how late ready comes and flips the ready polarity, so the release edge is pinned down by the slave's answer alone. A slave that never answers exposes the timeout length and the error flag.

The turnaround is checked with zero, one and several cycles while the next request is already waiting. This separates the required gap from an eager restart. Both address-latch polarities are exercised.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_TURN = 2'd3
  } lbm_phase_e;
endpackage

// File: rtl/lbm_seq.sv
module lbm_seq #(
  parameter int CNT_W   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              cfg_use_rdy,
  input  logic [CNT_W-1:0]  cfg_ale_cyc,
  input  logic [CNT_W-1:0]  cfg_strb_cyc,
  input  logic [CNT_W-1:0]  cfg_turn_cyc,
  input  logic              rdy_hit,
  output lbm_pkg::lbm_phase_e phase,
  output logic              accept,
  output logic              done,
  output logic              ack,
  output logic              err
);
  import lbm_pkg::*;
  localparam int TMO_W = $clog2(TMO_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tcnt;
  logic             tmo_hit;

  assign accept  = (phase == PH_IDLE) && req_valid && !ack;
  assign tmo_hit = cfg_use_rdy && (tcnt == TMO_W'(TMO_CYC - 1));
  assign done    = (phase == PH_STRB) &&
                   (cfg_use_rdy ? (rdy_hit || tmo_hit) : (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tcnt  <= '0;
      ack   <= 1'b0;
      err   <= 1'b0;
    end else begin
      ack <= done;
      if (done) err <= cfg_use_rdy && !rdy_hit;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_ADDR;
          cnt   <= cfg_ale_cyc;
        end
        PH_ADDR: if (cnt == '0) begin
          phase <= PH_STRB;
          cnt   <= cfg_strb_cyc;
          tcnt  <= '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        PH_STRB: if (done) begin
          phase <= (cfg_turn_cyc == '0) ? PH_IDLE : PH_TURN;
          cnt   <= cfg_turn_cyc - CNT_W'(1);
        end else begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          if (cfg_use_rdy) tcnt <= tcnt + TMO_W'(1);
        end
        PH_TURN: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R10
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STRB) |-> (tcnt < TMO_W'(TMO_CYC))); // R7
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    ack |-> (phase == PH_TURN || phase == PH_IDLE)); // R11
endmodule

// File: rtl/lbm_datapath.sv
module lbm_datapath #(
  parameter int LOC_AW = 16,
  parameter int DW     = 16,
  parameter int SEP_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              done,
  input  logic              req_write,
  input  logic [LOC_AW:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              cfg_wide,
  input  logic              cfg_swap,
  input  logic [DW-1:0]     lb_ad_i,
  output logic              cap_write,
  output logic              cap_win,
  output logic [LOC_AW-1:0] cap_addr,
  output logic [DW-1:0]     wfmt,
  output logic [SEP_AW-1:0] sep_addr,
  output logic [DW-1:0]     rdata
);
  localparam int NB = DW / 8;

  logic [DW-1:0] wdata_q, w_sw, r_sw, r_fmt;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign w_sw[g*8 +: 8] = wdata_q[(NB-1-g)*8 +: 8];
    assign r_sw[g*8 +: 8] = lb_ad_i[(NB-1-g)*8 +: 8];
  end

  assign wfmt  = cfg_wide ? (cfg_swap ? w_sw : wdata_q)
                          : {{(DW-8){1'b0}}, wdata_q[7:0]};
  assign r_fmt = cfg_wide ? (cfg_swap ? r_sw : lb_ad_i)
                          : {{(DW-8){1'b0}}, lb_ad_i[7:0]};
  assign sep_addr = cfg_wide ? cap_addr[SEP_AW:1] : cap_addr[SEP_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_write <= 1'b0;
      cap_win   <= 1'b0;
      cap_addr  <= '0;
      wdata_q   <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        cap_write <= req_write;
        cap_win   <= req_addr[LOC_AW];
        cap_addr  <= req_addr[LOC_AW-1:0];
        wdata_q   <= req_wdata;
      end
      if (done) rdata <= r_fmt;
    end
  end
endmodule

// File: rtl/lbus_master.sv
module lbus_master #(
  parameter int LOC_AW  = 16,
  parameter int DW      = 16,
  parameter int SEP_AW  = 10,
  parameter int CNT_W   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LOC_AW:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ack,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  input  logic              cfg_mux,
  input  logic              cfg_wide,
  input  logic              cfg_swap,
  input  logic              cfg_use_rdy,
  input  logic              cfg_ale_hi,
  input  logic              cfg_rdy_hi,
  input  logic [CNT_W-1:0]  cfg_ale_cyc,
  input  logic [CNT_W-1:0]  cfg_strb_cyc,
  input  logic [CNT_W-1:0]  cfg_turn_cyc,
  output logic [DW-1:0]     lb_ad_o,
  output logic              lb_ad_oe,
  input  logic [DW-1:0]     lb_ad_i,
  output logic [SEP_AW-1:0] lb_a,
  output logic              lb_ale,
  output logic              lb_rd_n,
  output logic              lb_wr_n,
  output logic              lb_cs0_n,
  output logic              lb_cs1_n,
  input  logic              lb_rdy
);
  import lbm_pkg::*;

  lbm_phase_e        phase;
  logic              accept, done, rdy_hit;
  logic              cap_write, cap_win;
  logic [LOC_AW-1:0] cap_addr;
  logic [DW-1:0]     wfmt;
  logic [SEP_AW-1:0] sep_addr;
  logic              in_addr, in_strb, active, ale_on;

  assign rdy_hit = (lb_rdy == cfg_rdy_hi);

  lbm_seq #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cfg_use_rdy(cfg_use_rdy),
    .cfg_ale_cyc(cfg_ale_cyc), .cfg_strb_cyc(cfg_strb_cyc),
    .cfg_turn_cyc(cfg_turn_cyc), .rdy_hit(rdy_hit), .phase(phase),
    .accept(accept), .done(done), .ack(req_ack), .err(rsp_err)
  );

  lbm_datapath #(.LOC_AW(LOC_AW), .DW(DW), .SEP_AW(SEP_AW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .done(done),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_wide(cfg_wide), .cfg_swap(cfg_swap), .lb_ad_i(lb_ad_i),
    .cap_write(cap_write), .cap_win(cap_win), .cap_addr(cap_addr),
    .wfmt(wfmt), .sep_addr(sep_addr), .rdata(rsp_rdata)
  );

  assign in_addr  = (phase == PH_ADDR);
  assign in_strb  = (phase == PH_STRB);
  assign active   = in_addr || in_strb;
  assign ale_on   = in_addr && cfg_mux;

  assign lb_cs0_n = !(active && !cap_win);
  assign lb_cs1_n = !(active && cap_win);
  assign lb_ale   = cfg_ale_hi ? ale_on : !ale_on;
  assign lb_rd_n  = !(in_strb && !cap_write);
  assign lb_wr_n  = !(in_strb && cap_write);
  assign lb_ad_oe = ale_on || (active && cap_write);
  assign lb_ad_o  = ale_on ? cap_addr[DW-1:0] : (lb_ad_oe ? wfmt : '0);
  assign lb_a     = cfg_mux ? '0 : sep_addr;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!lb_rd_n && !lb_wr_n)); // R5
  AST_CS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (lb_cs0_n || lb_cs1_n)); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (lb_ale == cfg_ale_hi) |-> (lb_rd_n && lb_wr_n)); // R3
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !lb_rd_n |-> !lb_ad_oe); // R9
  AST_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (lb_cs0_n && lb_cs1_n && lb_rd_n && lb_wr_n)); // R10
endmodule

// File: tb/tb_lbus_master.sv
module tb_lbus_master;
  localparam int TMO = 16;

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack, rsp_err, lb_ad_oe, lb_ale, lb_rd_n, lb_wr_n, lb_cs0_n, lb_cs1_n;
  logic [15:0] rsp_rdata, lb_ad_o;
  logic [15:0] lb_ad_i = '0;
  logic [9:0]  lb_a;
  logic        lb_rdy = 0;
  logic        cfg_mux = 1, cfg_wide = 1, cfg_swap = 0, cfg_use_rdy = 0;
  logic        cfg_ale_hi = 1, cfg_rdy_hi = 1;
  logic [3:0]  cfg_ale_cyc = 1, cfg_strb_cyc = 2, cfg_turn_cyc = 1;

  int errors = 0, checks = 0, gap_left = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lbus_master #(.TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cfg_mux(cfg_mux),
    .cfg_wide(cfg_wide), .cfg_swap(cfg_swap), .cfg_use_rdy(cfg_use_rdy),
    .cfg_ale_hi(cfg_ale_hi), .cfg_rdy_hi(cfg_rdy_hi), .cfg_ale_cyc(cfg_ale_cyc),
    .cfg_strb_cyc(cfg_strb_cyc), .cfg_turn_cyc(cfg_turn_cyc), .lb_ad_o(lb_ad_o),
    .lb_ad_oe(lb_ad_oe), .lb_ad_i(lb_ad_i), .lb_a(lb_a), .lb_ale(lb_ale),
    .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n), .lb_cs0_n(lb_cs0_n),
    .lb_cs1_n(lb_cs1_n), .lb_rdy(lb_rdy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [15:0] v);
    if (!cfg_wide) return {8'h00, v[7:0]};
    return cfg_swap ? {v[7:0], v[15:8]} : v;
  endfunction

  function automatic string ale_tag();
    if (!cfg_ale_hi) return "R12";
    return cfg_mux ? "R3" : "R4";
  endfunction

  task automatic check_quiet(input string tag, input bit exp_ack);
    chk(tag, "cs0_n", lb_cs0_n, 1);
    chk(tag, "cs1_n", lb_cs1_n, 1);
    chk(tag, "rd_n", lb_rd_n, 1);
    chk(tag, "wr_n", lb_wr_n, 1);
    chk(ale_tag(), "ale idle", lb_ale, !cfg_ale_hi);
    chk(tag, "ad_oe", lb_ad_oe, 0);
    chk(tag, "ack", req_ack, exp_ack);
  endtask

  task automatic check_cs(input bit win);
    chk("R2", "cs0_n", lb_cs0_n, win);
    chk("R2", "cs1_n", lb_cs1_n, !win);
  endtask

  task automatic check_a(input logic [16:0] addr);
    logic [9:0] ea;
    ea = cfg_mux ? 10'd0 : (cfg_wide ? addr[10:1] : addr[9:0]);
    chk("R4", "lb_a", lb_a, ea);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_quiet("R11", 0);
    end
    gap_left = (gap_left > n) ? gap_left - n : 0;
  endtask

  task automatic run_txn(input bit wr, input logic [16:0] addr, input logic [15:0] wd,
                         input logic [15:0] bus_rd, input int rdy_at);
    int n_strb;
    bit exp_err;
    string stag;
    n_strb  = cfg_use_rdy ? ((rdy_at <= TMO) ? rdy_at : TMO) : int'(cfg_strb_cyc) + 1;
    exp_err = cfg_use_rdy && (rdy_at > TMO);
    stag    = cfg_use_rdy ? (exp_err ? "R7" : "R6") : "R5";
    req_write = wr; req_addr = addr; req_wdata = wd; req_valid = 1;
    lb_ad_i = bus_rd;
    for (int i = 0; i < gap_left; i++) begin
      @(negedge clk);
      check_quiet("R11", 0);
    end
    for (int i = 0; i <= int'(cfg_ale_cyc); i++) begin
      @(negedge clk);
      check_cs(addr[16]);
      chk(ale_tag(), "ale addr phase", lb_ale, cfg_mux ? cfg_ale_hi : !cfg_ale_hi);
      chk("R5", "rd_n addr phase", lb_rd_n, 1);
      chk("R5", "wr_n addr phase", lb_wr_n, 1);
      chk("R3", "ad_oe addr phase", lb_ad_oe, cfg_mux ? 1 : wr);
      if (cfg_mux) chk("R3", "ad addr", lb_ad_o, addr[15:0]);
      else if (wr) chk("R8", "ad sep wdata", lb_ad_o, fmt(wd));
      check_a(addr);
      chk("R10", "ack addr phase", req_ack, 0);
    end
    for (int j = 1; j <= n_strb; j++) begin
      @(negedge clk);
      check_cs(addr[16]);
      chk(ale_tag(), "ale strobe", lb_ale, !cfg_ale_hi);
      chk(stag, "rd_n strobe", lb_rd_n, wr);
      chk(stag, "wr_n strobe", lb_wr_n, !wr);
      chk("R9", "ad_oe strobe", lb_ad_oe, wr);
      if (wr) chk("R8", "ad wdata", lb_ad_o, fmt(wd));
      check_a(addr);
      chk("R10", "ack strobe", req_ack, 0);
      lb_rdy = (cfg_use_rdy && j == rdy_at) ? cfg_rdy_hi : !cfg_rdy_hi;
    end
    @(negedge clk);
    lb_rdy = !cfg_rdy_hi;
    check_quiet("R10", 1);
    if (!wr) chk("R9", "rdata", rsp_rdata, fmt(bus_rd));
    chk("R7", "err", rsp_err, exp_err);
    req_valid = 0;
    gap_left = (cfg_turn_cyc == 0) ? 1 : int'(cfg_turn_cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1", 0);
    chk("R1", "rdata reset", rsp_rdata, 0);
    rst = 0;
    idle_cycles(2);
    // multiplexed, 16-bit, counted
    run_txn(1, 17'h0_1234, 16'hA55A, 16'h0, 0);
    run_txn(0, 17'h1_BEEF, 16'h0, 16'hC3D2, 0);
    cfg_swap = 1; cfg_ale_cyc = 0; cfg_strb_cyc = 4;
    run_txn(1, 17'h1_00F0, 16'h1122, 16'h0, 0);
    run_txn(0, 17'h0_0F0F, 16'h0, 16'h3344, 0);
    // separate style
    idle_cycles(3);
    cfg_mux = 0; cfg_wide = 0; cfg_swap = 0; cfg_ale_cyc = 2; cfg_strb_cyc = 1;
    run_txn(1, 17'h0_07FF, 16'hABCD, 16'h0, 0);
    run_txn(0, 17'h1_0355, 16'h0, 16'h9876, 0);
    idle_cycles(2);
    cfg_wide = 1; cfg_swap = 1;
    run_txn(0, 17'h0_05A6, 16'h0, 16'h5A01, 0);
    run_txn(1, 17'h1_0003, 16'hF00D, 16'h0, 0);
    // ready-terminated cycles
    idle_cycles(2);
    cfg_mux = 1; cfg_swap = 0; cfg_use_rdy = 1; cfg_ale_cyc = 1;
    run_txn(0, 17'h0_4321, 16'h0, 16'h7E7E, 3);
    run_txn(1, 17'h1_8000, 16'h0102, 16'h0, 1);
    idle_cycles(2);
    cfg_rdy_hi = 0; lb_rdy = 1;
    run_txn(0, 17'h1_1111, 16'h0, 16'h2468, 5);
    run_txn(0, 17'h0_2222, 16'h0, 16'h1357, 100);
    run_txn(1, 17'h0_3333, 16'h4444, 16'h0, 2);
    // ALE polarity and turnaround
    idle_cycles(2);
    cfg_use_rdy = 0; cfg_ale_hi = 0; cfg_turn_cyc = 0;
    run_txn(1, 17'h0_0A0A, 16'h5555, 16'h0, 0);
    run_txn(0, 17'h1_0B0B, 16'h0, 16'h6666, 0);
    cfg_turn_cyc = 3;
    run_txn(1, 17'h0_0C0C, 16'h7777, 16'h0, 0);
    run_txn(0, 17'h1_0D0D, 16'h0, 16'h8888, 0);
    idle_cycles(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule